// File: doc/BRIEF.md
# Variable-Length Instruction Decode and Execute Core

This block is a small sequential processor core for a toy instruction set. It fetches 16-bit base instructions from an instruction memory port. Some instructions carry a trailing 16-bit or 32-bit signed immediate. The core decodes each instruction and executes it against a 16-entry, 32-bit register file and a four-bit status field. The supported operations are register adds that set flags, immediate adds that leave the flags alone, register-pair moves, two instructions that treat the source register field as a value or as an index offset, and five load forms with different widths and extensions. Each instruction runs as a fixed sequence of states: base fetch, zero to two immediate fetches, execute, and, for loads, a data request and data wait. No two instructions overlap.

Both memory ports are request streams with a valid/ready handshake. Once the core raises a request valid, it holds the request and its address unchanged until the cycle in which ready is high. That cycle is the acceptance cycle. The environment returns the response data on the following cycle, and the core does not stall waiting for it. Ready may stay low for any number of cycles, and the core simply waits.

The data port returns four little-endian bytes starting at the requested byte address, with the byte at that address in bits 7:0. The core selects and extends the width it needs. A combinational read port exposes any register for observation.

Top module: `toy_core`

## Requirements
- R1: After reset, the first fetch is at address 0. Each instruction is made of 16-bit words stored in order: the base word, then the low half of the immediate, then its high half. The program counter advances by 2, 4 or 6 bytes according to the instruction length, and every fetch address is even.
- R2: Base words use primary opcode in bits 15:12, secondary opcode in bits 11:8, destination register in bits 7:4 and source register in bits 3:0. Primary 4 with secondary 0 or 1 writes dst+src to the destination. It sets V to the signed overflow, C to the carry out, and Z and N from the result. The flag field is packed with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R3: Primary 4 with secondary 2 writes src plus the sign-extended 16-bit immediate into the destination. The flags do not change, and the instruction is 4 bytes long.
- R4: Primary 4 with secondary 3 writes src plus the 32-bit immediate, modulo 2^32, into the destination. The flags do not change, and the instruction is 6 bytes long.
- R5: Primary 5 with secondary 2 writes reg[src] to reg[dst] and reg[(src+1) mod 16] to reg[(dst+1) mod 16]. Both values are read before either write takes effect.
- R6: Primary 5 with secondary 3 writes the source field number itself, zero-extended, into the destination.
- R7: Primary 5 with secondary 4 writes reg[(src+1) mod 16] into the destination.
- R8: Primary 2 loads from the byte address held in the source register. Secondary 12 loads a word. Secondary 8 loads a sign-extended byte and secondary 9 a zero-extended byte. Secondary 10 loads a sign-extended halfword and secondary 11 a zero-extended halfword. The size code on the data port is 0 for a byte, 1 for a halfword and 2 for a word.
- R9: Any other encoding is 2 bytes long. When it retires, the illegal output pulses, and no register or flag changes.
- R10: A request that is not yet accepted stays valid with a stable address. The two ports never request in the same cycle.
- R11: Reset clears every register, the flags, and the program counter, and no instruction retires during reset.
- R12: The retire output pulses for exactly one cycle per instruction. The flags change only at the end of a retiring cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_req_valid | output | 1 | Instruction fetch request valid |
| imem_req_ready | input | 1 | Instruction port accepts the request |
| imem_addr | output | 32 | Byte address of the requested 16-bit word |
| imem_rdata | input | 16 | Fetched word, one cycle after acceptance |
| dmem_req_valid | output | 1 | Data load request valid |
| dmem_req_ready | input | 1 | Data port accepts the request |
| dmem_addr | output | 32 | Byte address of the load |
| dmem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| dmem_rdata | input | 32 | Four bytes from the address, one cycle after acceptance |
| retire | output | 1 | One-cycle pulse as an instruction completes |
| illegal | output | 1 | Pulses with retire for an undefined encoding |
| flags | output | 4 | Status field {N,Z,V,C} |
| dbg_idx | input | 4 | Register selected for observation |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The embedded assertions check the following on every clock:
- requests hold their address while stalled;
- the two ports never request in the same cycle;
- fetch addresses are even;
- retire lasts one cycle;
- illegal only accompanies retire and leaves the flags alone;
- the flags move only at retirement;
- the pair move never writes the same register twice.

Only the bench scenarios can show the following:
- the arithmetic and flag values;
- sign versus zero extension for each load form;
- the mod-16 wrap of register numbers;
- the read-before-write ordering of the pair move;
- the program-counter stride for each length.

These are checked under a ready pattern that stalls both ports.

// File: rtl/toy_pkg.sv
package toy_pkg;
  localparam int HW = 16;

  typedef enum logic [2:0] {
    OP_ADD, OP_ADDI, OP_PAIR, OP_REGNUM, OP_IDX, OP_LOAD, OP_BAD
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] imm_words;
    logic [1:0] ld_size;
    logic       ld_signed;
    logic       illegal;
  } dec_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/toy_decode.sv
module toy_decode
  import toy_pkg::*;
(
  input  logic [HW-1:0] word,
  output dec_t          dec
);
  logic [3:0] prim, sec;
  assign prim = word[15:12];
  assign sec  = word[11:8];

  always_comb begin
    dec.op        = OP_BAD;
    dec.imm_words = 2'd0;
    dec.ld_size   = 2'd2;
    dec.ld_signed = 1'b0;
    dec.illegal   = 1'b1;
    unique case (prim)
      4'h4: begin
        if (sec == 4'h0 || sec == 4'h1) begin
          dec.op = OP_ADD; dec.illegal = 1'b0;
        end else if (sec == 4'h2) begin
          dec.op = OP_ADDI; dec.imm_words = 2'd1; dec.illegal = 1'b0;
        end else if (sec == 4'h3) begin
          dec.op = OP_ADDI; dec.imm_words = 2'd2; dec.illegal = 1'b0;
        end
      end
      4'h5: begin
        if (sec == 4'h2) begin
          dec.op = OP_PAIR; dec.illegal = 1'b0;
        end else if (sec == 4'h3) begin
          dec.op = OP_REGNUM; dec.illegal = 1'b0;
        end else if (sec == 4'h4) begin
          dec.op = OP_IDX; dec.illegal = 1'b0;
        end
      end
      4'h2: begin
        if (sec >= 4'h8 && sec <= 4'hC) begin
          dec.op      = OP_LOAD;
          dec.illegal = 1'b0;
          dec.ld_size = (sec == 4'hC) ? 2'd2 : ((sec >= 4'hA) ? 2'd1 : 2'd0);
          dec.ld_signed = (sec == 4'h8) || (sec == 4'hA);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/toy_regfile.sv
module toy_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we0,
  input  logic [RIDX-1:0] wa0,
  input  logic [XLEN-1:0] wd0,
  input  logic            we1,
  input  logic [RIDX-1:0] wa1,
  input  logic [XLEN-1:0] wd1,
  input  logic [RIDX-1:0] ra0,
  input  logic [RIDX-1:0] ra1,
  input  logic [RIDX-1:0] ra2,
  input  logic [RIDX-1:0] ra3,
  output logic [XLEN-1:0] rd0,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  output logic [XLEN-1:0] rd3
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (we0) regs[wa0] <= wd0;
      if (we1) regs[wa1] <= wd1;
    end
  end

  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];

  // R5
  pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && we1) |-> (wa0 != wa1));
endmodule

// File: rtl/toy_exec.sv
module toy_exec
  import toy_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  dec_t            dec,
  input  logic [3:0]      src_num,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] src1_val,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] mem_word,
  input  flags_t          flags_in,
  output logic [XLEN-1:0] res0,
  output logic [XLEN-1:0] res1,
  output flags_t          flags_out,
  output logic [XLEN-1:0] ld_val
);
  logic [XLEN:0]   wide_sum;
  logic [XLEN-1:0] sum;

  assign wide_sum = {1'b0, dst_val} + {1'b0, src_val};
  assign sum      = wide_sum[XLEN-1:0];

  always_comb begin
    res0      = dst_val;
    res1      = src1_val;
    flags_out = flags_in;
    unique case (dec.op)
      OP_ADD: begin
        res0        = sum;
        flags_out.c = wide_sum[XLEN];
        flags_out.v = (dst_val[XLEN-1] == src_val[XLEN-1]) &&
                      (sum[XLEN-1] != dst_val[XLEN-1]);
        flags_out.z = (sum == '0);
        flags_out.n = sum[XLEN-1];
      end
      OP_ADDI:   res0 = src_val + imm;
      OP_PAIR:   res0 = src_val;
      OP_REGNUM: res0 = XLEN'(src_num);
      OP_IDX:    res0 = src1_val;
      default:   ;
    endcase
  end

  always_comb begin
    unique case (dec.ld_size)
      2'd0:    ld_val = dec.ld_signed ? XLEN'($signed(mem_word[7:0]))  : XLEN'(mem_word[7:0]);
      2'd1:    ld_val = dec.ld_signed ? XLEN'($signed(mem_word[15:0])) : XLEN'(mem_word[15:0]);
      default: ld_val = mem_word;
    endcase
  end
endmodule

// File: rtl/toy_core.sv
module toy_core
  import toy_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            imem_req_valid,
  input  logic            imem_req_ready,
  output logic [XLEN-1:0] imem_addr,
  input  logic [HW-1:0]   imem_rdata,
  output logic            dmem_req_valid,
  input  logic            dmem_req_ready,
  output logic [XLEN-1:0] dmem_addr,
  output logic [1:0]      dmem_size,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            retire,
  output logic            illegal,
  output logic [3:0]      flags,
  input  logic [RIDX-1:0] dbg_idx,
  output logic [XLEN-1:0] dbg_data
);
  typedef enum logic [2:0] {
    S_FETCH, S_FWAIT, S_IREQ, S_IWAIT, S_EXEC, S_DREQ, S_DWAIT
  } state_e;

  state_e          state;
  logic [XLEN-1:0] pc;
  logic [HW-1:0]   ir, imm_lo, imm_hi;
  logic            cnt;
  flags_t          flg;
  dec_t            dec;
  logic [HW-1:0]   dec_word;

  logic [RIDX-1:0] dst_idx, src_idx, src1_idx, dst1_idx;
  logic [XLEN-1:0] dst_val, src_val, src1_val, imm_val;
  logic [XLEN-1:0] res0, res1, ld_val;
  flags_t          flg_next;
  logic [2:0]      ilen;
  logic            we0, we1;

  assign dec_word = (state == S_FWAIT) ? imem_rdata : ir;

  toy_decode u_dec (.word(dec_word), .dec(dec));

  assign dst_idx  = ir[7:4];
  assign src_idx  = ir[3:0];
  assign src1_idx = src_idx + RIDX'(1);
  assign dst1_idx = dst_idx + RIDX'(1);

  assign imm_val = (dec.imm_words == 2'd2) ? XLEN'($signed({imm_hi, imm_lo}))
                                           : XLEN'($signed(imm_lo));

  toy_exec #(.XLEN(XLEN)) u_exec (
    .dec(dec), .src_num(ir[3:0]), .dst_val(dst_val), .src_val(src_val),
    .src1_val(src1_val), .imm(imm_val), .mem_word(dmem_rdata), .flags_in(flg),
    .res0(res0), .res1(res1), .flags_out(flg_next), .ld_val(ld_val)
  );

  assign we0 = ((state == S_EXEC) && !dec.illegal && (dec.op != OP_LOAD)) ||
               (state == S_DWAIT);
  assign we1 = (state == S_EXEC) && (dec.op == OP_PAIR);

  toy_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we0(we0), .wa0(dst_idx), .wd0((state == S_DWAIT) ? ld_val : res0),
    .we1(we1), .wa1(dst1_idx), .wd1(res1),
    .ra0(dst_idx), .ra1(src_idx), .ra2(src1_idx), .ra3(dbg_idx),
    .rd0(dst_val), .rd1(src_val), .rd2(src1_val), .rd3(dbg_data)
  );

  assign ilen = {dec.imm_words, 1'b0} + 3'd2;

  assign imem_req_valid = (state == S_FETCH) || (state == S_IREQ);
  assign imem_addr      = (state == S_IREQ) ? pc + XLEN'({cnt, 1'b0}) + XLEN'(2) : pc;
  assign dmem_req_valid = (state == S_DREQ);
  assign dmem_addr      = src_val;
  assign dmem_size      = dec.ld_size;
  assign retire  = ((state == S_EXEC) && (dec.op != OP_LOAD)) || (state == S_DWAIT);
  assign illegal = (state == S_EXEC) && dec.illegal;
  assign flags   = flg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_FETCH;
      pc     <= '0;
      ir     <= '0;
      imm_lo <= '0;
      imm_hi <= '0;
      cnt    <= 1'b0;
      flg    <= '0;
    end else begin
      unique case (state)
        S_FETCH: if (imem_req_ready) state <= S_FWAIT;
        S_FWAIT: begin
          ir  <= imem_rdata;
          cnt <= 1'b0;
          state <= (!dec.illegal && dec.imm_words != 2'd0) ? S_IREQ : S_EXEC;
        end
        S_IREQ: if (imem_req_ready) state <= S_IWAIT;
        S_IWAIT: begin
          if (!cnt) imm_lo <= imem_rdata;
          else      imm_hi <= imem_rdata;
          if (!cnt && dec.imm_words == 2'd2) begin
            cnt   <= 1'b1;
            state <= S_IREQ;
          end else begin
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (dec.op == OP_LOAD) begin
            state <= S_DREQ;
          end else begin
            pc    <= pc + XLEN'(ilen);
            state <= S_FETCH;
            if (dec.op == OP_ADD) flg <= flg_next;
          end
        end
        S_DREQ: if (dmem_req_ready) state <= S_DWAIT;
        S_DWAIT: begin
          pc    <= pc + XLEN'(2);
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  // R10
  imem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req_valid && !imem_req_ready) |=> (imem_req_valid && $stable(imem_addr)));
  // R10
  dmem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_req_valid && !dmem_req_ready) |=> (dmem_req_valid && $stable(dmem_addr)));
  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_req_valid && dmem_req_valid));
  // R1
  even_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_valid |-> (imem_addr[0] == 1'b0));
  // R12
  retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);
  // R12
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(flags));
  // R9
  illegal_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> retire);
  // R9
  illegal_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(flags));
endmodule

// File: tb/test_toy_core.sv
module test_toy_core;
  typedef struct packed {
    logic [47:0] words;
    logic [1:0]  nw;
    logic [3:0]  ra;
    logic [31:0] va;
    logic [3:0]  rb;
    logic [31:0] vb;
    logic [3:0]  fl;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{48'h7FFF_FFFF_4310, 2'd3, 4'd1,  32'h7FFFFFFF, 4'd0,  32'h0,        4'h0, 1'b0, 4'd4}, // R4
    '{48'h0000_0001_4220, 2'd2, 4'd2,  32'h1,        4'd1,  32'h7FFFFFFF, 4'h0, 1'b0, 4'd3}, // R3
    '{48'h0000_0000_4012, 2'd1, 4'd1,  32'h80000000, 4'd2,  32'h1,        4'hA, 1'b0, 4'd2}, // R2 overflow
    '{48'h0000_FFFF_4230, 2'd2, 4'd3,  32'hFFFFFFFF, 4'd1,  32'h80000000, 4'hA, 1'b0, 4'd3}, // R3 negative imm
    '{48'h0000_0000_4132, 2'd1, 4'd3,  32'h0,        4'd2,  32'h1,        4'h5, 1'b0, 4'd2}, // R2 carry, zero
    '{48'h0000_0010_4240, 2'd2, 4'd4,  32'h10,       4'd3,  32'h0,        4'h5, 1'b0, 4'd3}, // R3
    '{48'h0000_0000_2C54, 2'd1, 4'd5,  32'h92348AF0, 4'd4,  32'h10,       4'h5, 1'b0, 4'd8}, // R8 word
    '{48'h0000_0000_2864, 2'd1, 4'd6,  32'hFFFFFFF0, 4'd5,  32'h92348AF0, 4'h5, 1'b0, 4'd8}, // R8 sbyte
    '{48'h0000_0000_2974, 2'd1, 4'd7,  32'h000000F0, 4'd6,  32'hFFFFFFF0, 4'h5, 1'b0, 4'd8}, // R8 ubyte
    '{48'h0000_0000_2A84, 2'd1, 4'd8,  32'hFFFF8AF0, 4'd7,  32'h000000F0, 4'h5, 1'b0, 4'd8}, // R8 shalf
    '{48'h0000_0000_2B94, 2'd1, 4'd9,  32'h00008AF0, 4'd8,  32'hFFFF8AF0, 4'h5, 1'b0, 4'd8}, // R8 uhalf
    '{48'h0000_0000_52A5, 2'd1, 4'd10, 32'h92348AF0, 4'd11, 32'hFFFFFFF0, 4'h5, 1'b0, 4'd5}, // R5
    '{48'h0000_0000_53C9, 2'd1, 4'd12, 32'h9,        4'd9,  32'h00008AF0, 4'h5, 1'b0, 4'd6}, // R6
    '{48'h0000_0000_54D4, 2'd1, 4'd13, 32'h92348AF0, 4'd4,  32'h10,       4'h5, 1'b0, 4'd7}, // R7
    '{48'h0000_0000_52F1, 2'd1, 4'd15, 32'h80000000, 4'd0,  32'h1,        4'h5, 1'b0, 4'd5}, // R5 wrap
    '{48'h0000_0000_54EF, 2'd1, 4'd14, 32'h1,        4'd15, 32'h80000000, 4'h5, 1'b0, 4'd7}, // R7 wrap
    '{48'h0000_0000_7000, 2'd1, 4'd0,  32'h1,        4'd14, 32'h1,        4'h5, 1'b1, 4'd9}, // R9
    '{48'h0000_0000_2D12, 2'd1, 4'd2,  32'h1,        4'd1,  32'h80000000, 4'h5, 1'b1, 4'd9}, // R9
    '{48'h8000_0000_4321, 2'd3, 4'd2,  32'h0,        4'd1,  32'h80000000, 4'h5, 1'b0, 4'd4}, // R4 wrap
    '{48'h0000_0000_4033, 2'd1, 4'd3,  32'h0,        4'd2,  32'h0,        4'h4, 1'b0, 4'd2}, // R2 zero only
    '{48'h0000_0000_5254, 2'd1, 4'd5,  32'h10,       4'd6,  32'h92348AF0, 4'h4, 1'b0, 4'd5}  // R5 overlap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req_valid, imem_req_ready = 1'b0;
  logic [31:0] imem_addr;
  logic [15:0] imem_rdata = '0;
  logic        dmem_req_valid, dmem_req_ready = 1'b0;
  logic [31:0] dmem_addr;
  logic [1:0]  dmem_size;
  logic [31:0] dmem_rdata = '0;
  logic        retire, illegal;
  logic [3:0]  flags;
  logic [3:0]  dbg_idx = '0;
  logic [31:0] dbg_data;

  logic [15:0] imem [128];
  logic [7:0]  dmem [64];
  int n_chk = 0, n_bad = 0, cyc = 0, hs_err = 0;
  logic        p_valid = 1'b0, p_ready = 1'b0;
  logic [31:0] p_addr = '0;

  always #10 clk = ~clk;

  toy_core i_toy_core (
    .clk(clk), .rst_n(rst_n),
    .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_req_valid(dmem_req_valid), .dmem_req_ready(dmem_req_ready),
    .dmem_addr(dmem_addr), .dmem_size(dmem_size), .dmem_rdata(dmem_rdata),
    .retire(retire), .illegal(illegal), .flags(flags),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  // memory models and stall pattern (R10)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    imem_req_ready <= (cyc % 3) != 2;
    dmem_req_ready <= (cyc % 4) != 1;
    if (imem_req_valid && imem_req_ready) imem_rdata <= imem[imem_addr[7:1]];
    if (dmem_req_valid && dmem_req_ready)
      dmem_rdata <= {dmem[dmem_addr[5:0] + 6'd3], dmem[dmem_addr[5:0] + 6'd2],
                     dmem[dmem_addr[5:0] + 6'd1], dmem[dmem_addr[5:0]]};
  end

  // handshake monitor (R10)
  always @(negedge clk) begin
    if (rst_n && p_valid && !p_ready && (!imem_req_valid || imem_addr != p_addr))
      hs_err++;
    p_valid = imem_req_valid;
    p_ready = imem_req_ready;
    p_addr  = imem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] val);
    dbg_idx = idx;
    #1 val = dbg_data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog actual=hang expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] exp_pc;
    logic        got_ill;
    int          wi;
    for (int i = 0; i < 128; i++) imem[i] = 16'h0000;
    for (int i = 0; i < 64; i++) dmem[i] = 8'h00;
    dmem[16] = 8'hF0; dmem[17] = 8'h8A; dmem[18] = 8'h34; dmem[19] = 8'h92;
    wi = 0;
    for (int k = 0; k < NV; k++) begin
      for (int w = 0; w < 3; w++)
        if (w < int'(VEC[k].nw)) begin
          imem[wi] = VEC[k].words[16*w +: 16];
          wi++;
        end
    end

    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 flags in reset", 32'(flags), 32'h0);
    chk("R11 retire in reset", 32'(retire), 32'h0);
    rd(4'd7, v); chk("R11 r7 in reset", v, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    while (!imem_req_valid) @(negedge clk);
    chk("R1 first fetch address", imem_addr, 32'h0);

    exp_pc = 32'h0;
    for (int k = 0; k < NV; k++) begin
      while (!retire) @(negedge clk);
      got_ill = illegal;
      @(negedge clk);
      chk($sformatf("R12 vec%0d retire single pulse", k), 32'(retire), 32'h0);
      rd(VEC[k].ra, v);
      chk($sformatf("R%0d vec%0d reg r%0d", VEC[k].req, k, VEC[k].ra), v, VEC[k].va);
      rd(VEC[k].rb, v);
      chk($sformatf("R%0d vec%0d reg r%0d", VEC[k].req, k, VEC[k].rb), v, VEC[k].vb);
      chk($sformatf("R%0d vec%0d flags", VEC[k].req, k), 32'(flags), 32'(VEC[k].fl));
      chk($sformatf("R9 vec%0d illegal pulse", k), 32'(got_ill), 32'(VEC[k].ill));
      exp_pc = exp_pc + 32'(2 * int'(VEC[k].nw));
      while (!imem_req_valid) @(negedge clk);
      chk($sformatf("R1 vec%0d next pc", k), imem_addr, exp_pc);
    end

    chk("R10 stalled fetch held stable", 32'(hs_err), 32'h0);

    // R11 reset in mid-run clears state
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R11 flags after reset", 32'(flags), 32'h0);
    rd(4'd5, v); chk("R11 r5 after reset", v, 32'h0);
    rd(4'd15, v); chk("R11 r15 after reset", v, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    while (!imem_req_valid) @(negedge clk);
    chk("R11 fetch restarts at zero", imem_addr, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule